// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. Each character frame is one low start bit, then 8 or 9 data bits sent least significant bit first, then one high stop bit. A programmable divider makes an oversampling tick, and one bit time is sixteen ticks long.

The receiver decides each data bit by a majority of three samples taken around the middle of the bit. It decides the start and stop bits by a majority of seven samples spread across the bit. Its bit counter is pulled back into line on every falling edge between data bits, so a sender whose rate is a few percent off is still received. A standby mode lets a node on a shared line skip characters meant for other nodes. The hardware leaves standby by itself once the line has been idle for a whole frame.

The transmitter has a one-character holding register in front of a shift register. It can send a data character, a full character of ones (idle) or a full character of zeros (break). It reports when the holding register is free, and separately when the line has finished shifting. The host side is a plain strobe-and-data port.

Top module: `mv_uart`

## Requirements
- R1: A frame is a 0 start bit, then the data bits LSB first, then a 1 stop bit. There are 9 data bits when `nine_bit`=1 and 8 otherwise. A received 8-bit character appears on `rx_data` with bit 8 cleared, and `rx_data` changes only when a character is accepted.
- R2: A received data bit takes the majority value of three samples at oversampling ticks 7, 8 and 9 of the bit, so one corrupted sample does not change it.
- R3: The start and stop bits each take a majority of seven samples, at ticks 3, 5, 7, 8, 9, 11 and 13. One corrupted sample changes neither bit. A low pulse whose start-bit majority is 1 is dropped as a false start.
- R4: A falling edge seen while data bits are being received realigns the bit counter, so a sender running at 17 ticks per bit is still received correctly.
- R5: `rx_frame_err` is updated with each accepted character. It is 1 when the stop-bit majority is 0, and 0 otherwise.
- R6: When a character completes while `rx_valid` is 1 and `rx_rd` is not asserted, the old character is kept and `rx_overrun` is set. `rx_rd` clears both `rx_valid` and `rx_overrun`.
- R7: A pulse on `rx_sleep` sets `rx_asleep`. While it is set, received characters change none of the receive outputs. It clears by itself after 10 bit times of continuous idle line (11 bit times with 9-bit frames), counted from the later of the sleep request and the end of the last frame. A shorter idle period leaves it set.
- R8: `tx_kind` chooses what is queued: 2'b00 sends a data character, 2'b01 sends a whole frame of 1s (idle), and 2'b10 sends a whole frame of 0s (break). A frame is 10 or 11 bit times long, matching `nine_bit`.
- R9: `tx_empty` falls on an accepted write and rises when the character moves into the shift register. A write while `tx_empty`=0 is ignored.
- R10: `tx_done` is 0 from an accepted write until the last bit of the last queued frame has been shifted out. It is 1 otherwise, and whenever it is 1 `txd` is high.
- R11: The oversampling tick fires once every `baud_div`+1 clocks, and each bit lasts 16 ticks. A break frame in 8-bit mode with `baud_div`=1 therefore holds `txd` low for 320 clocks.
- R12: After reset `txd`=1, `tx_empty`=1, `tx_done`=1, `rx_valid`=0, `rx_overrun`=0 and `rx_asleep`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | DIV_W | Tick divider; one tick every baud_div+1 clocks |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_kind | input | 2 | 00 data, 01 idle frame, 10 break frame |
| tx_data | input | 9 | Character to transmit |
| rx_rd | input | 1 | Read acknowledge; clears rx_valid and rx_overrun |
| rx_sleep | input | 1 | Pulse that enters receiver standby |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Transmitter fully idle |
| rx_data | output | 9 | Last accepted character |
| rx_valid | output | 1 | Unread character present |
| rx_frame_err | output | 1 | Stop-bit majority was 0 for the last accepted character |
| rx_overrun | output | 1 | A character was lost while rx_valid was 1 |
| rx_asleep | output | 1 | Receiver in standby |

## Verification
The hardest cases to reach from the ports are a single bad sample inside one bit and a sender whose bit time drifts against the receiver. A loopback through the block's own transmitter never produces either. For these cases the bench drives the receive line itself with the divider at 1, so one tick is two clocks. It places a two-clock glitch at tick 8 of a chosen start, data or stop bit, so exactly one vote sample is corrupted. It also sends an alternating byte at 34 clocks per bit, which fails without edge realignment well before the stop bit. Standby wake timing is checked by sampling the standby output at points before and after the ten-bit idle threshold.

// File: rtl/mv_uart_pkg.sv
// Shared constants and types for the majority-vote transceiver.
// Assumes a fixed 16x oversampling ratio; the sample tick positions below depend on it.
package mv_uart_pkg;
    localparam int OSR  = 16;
    localparam int TW   = $clog2(OSR);
    localparam int DMAX = 9;
    localparam int FMAX = DMAX + 2;
    localparam int IW   = $clog2(FMAX * OSR + 1);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;
    typedef enum logic [1:0] {TXK_DATA = 2'b00, TXK_IDLE = 2'b01, TXK_BREAK = 2'b10} tx_kind_t;
endpackage

// File: rtl/mv_uart_baud.sv
// Oversampling tick generator: one single-cycle tick every div+1 clocks.
// Assumes div may change at any time; the counter restarts once it reaches div.
module mv_uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    // Count clocks between ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R11: a nonzero divider never gives two ticks in a row
    p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/mv_uart_rx.sv
// Receiver: 2-stage synchronizer, 7-sample start/stop vote, 3-sample data vote,
// falling-edge realignment during data bits, overrun and standby handling.
// Assumes tick is the 16x oversampling strobe from mv_uart_baud.
module mv_uart_rx
    import mv_uart_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            nine,
    input  logic            rxd,
    input  logic            rd,
    input  logic            sleep_req,
    output logic [DMAX-1:0] data,
    output logic            valid,
    output logic            ferr,
    output logic            ovr,
    output logic            asleep
);
    logic            s1, s2, prev;
    rx_st_t          st;
    logic [TW-1:0]   cnt;
    logic [2:0]      ones, ones_nx;
    logic [3:0]      idx, nbits;
    logic [DMAX-1:0] sh;
    logic            done_p, stop_ok, fall, pt7, pt3;
    logic [IW-1:0]   idle_cnt, thr;

    assign fall  = tick && prev && !s2;
    assign nbits = nine ? 4'd9 : 4'd8;
    assign thr   = nine ? IW'(11 * OSR) : IW'(10 * OSR);
    assign pt3   = (cnt == TW'(7)) || (cnt == TW'(8)) || (cnt == TW'(9));
    assign pt7   = pt3 || (cnt == TW'(3)) || (cnt == TW'(5)) || (cnt == TW'(11)) || (cnt == TW'(13));
    assign ones_nx = ones + {2'b00, s2 && ((st == RX_DATA) ? pt3 : pt7)};

    // Synchronize the line and keep the previous tick's sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
            if (tick) prev <= s2;
        end
    end

    // Frame state machine: bit counting, voting and edge realignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= RX_IDLE; cnt <= '0; ones <= '0; idx <= '0;
            sh <= '0; done_p <= 1'b0; stop_ok <= 1'b0;
        end else begin
            done_p <= 1'b0;
            if (tick) begin
                case (st)
                    RX_IDLE: if (fall) begin
                        st <= RX_START; cnt <= TW'(1); ones <= '0;
                    end
                    RX_START: if (cnt == TW'(OSR - 1)) begin
                        st   <= (ones_nx >= 3'd4) ? RX_IDLE : RX_DATA;
                        cnt  <= '0; ones <= '0; idx <= '0;
                    end else begin
                        cnt <= cnt + 1'b1; ones <= ones_nx;
                    end
                    RX_DATA: if (fall && cnt <= TW'(5)) begin
                        cnt <= TW'(1); ones <= '0;
                    end else if ((fall && cnt >= TW'(11)) || cnt == TW'(OSR - 1)) begin
                        sh[idx] <= (ones >= 3'd2);
                        idx     <= idx + 1'b1;
                        cnt     <= fall ? TW'(1) : TW'(0);
                        ones    <= '0;
                        if (idx == nbits - 4'd1) st <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1; ones <= ones_nx;
                    end
                    RX_STOP: if (cnt == TW'(14)) begin
                        st <= RX_IDLE; done_p <= 1'b1; stop_ok <= (ones >= 3'd4); cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1; ones <= ones_nx;
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    // Hand a finished character to the host, or flag overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0; valid <= 1'b0; ferr <= 1'b0; ovr <= 1'b0;
        end else begin
            if (rd) begin valid <= 1'b0; ovr <= 1'b0; end
            if (done_p && !asleep) begin
                if (valid && !rd) ovr <= 1'b1;
                else begin
                    data  <= nine ? sh : {1'b0, sh[7:0]};
                    valid <= 1'b1;
                    ferr  <= !stop_ok;
                end
            end
        end
    end

    // Standby: enter on request, leave after a full frame of idle line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep <= 1'b0; idle_cnt <= '0;
        end else if (sleep_req) begin
            asleep <= 1'b1; idle_cnt <= '0;
        end else begin
            if (tick) begin
                if (st == RX_IDLE && s2) begin
                    if (idle_cnt < thr) idle_cnt <= idle_cnt + 1'b1;
                end else idle_cnt <= '0;
            end
            if (asleep && idle_cnt >= thr) asleep <= 1'b0;
        end
    end

    // R7: no character reaches the host while in standby
    p_sleep_holds_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> $stable(data));
    // R6: an overrun is only ever reported alongside an unread character
    p_ovr_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> valid);
    // R1: the data output only moves when a character is accepted
    p_data_on_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data) |-> valid);
endmodule

// File: rtl/mv_uart_tx.sv
// Transmitter: holding register plus frame shifter; sends data, idle or break frames.
// Assumes tick is the 16x strobe; a queued frame follows the previous stop bit directly.
module mv_uart_tx
    import mv_uart_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            nine,
    input  logic            wr,
    input  logic [1:0]      kind,
    input  logic [DMAX-1:0] din,
    output logic            txd,
    output logic            empty,
    output logic            done
);
    logic [FMAX-1:0] sh, frm;
    logic [3:0]      left, nb;
    logic [TW-1:0]   cnt;
    logic            busy, empty_q;
    logic [DMAX-1:0] hold_d;
    logic [1:0]      hold_k;

    assign nb    = nine ? 4'd11 : 4'd10;
    assign txd   = busy ? sh[0] : 1'b1;
    assign empty = empty_q;
    assign done  = !busy && empty_q;

    // Build the frame image for the held character.
    always_comb begin
        case (hold_k)
            TXK_IDLE:  frm = '1;
            TXK_BREAK: frm = '0;
            default:   frm = nine ? {1'b1, hold_d, 1'b0} : {2'b11, hold_d[7:0], 1'b0};
        endcase
    end

    // Accept writes, load the shifter at frame boundaries and shift bits out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '1; left <= '0; cnt <= '0; busy <= 1'b0;
            hold_d <= '0; hold_k <= '0; empty_q <= 1'b1;
        end else begin
            if (wr && empty_q) begin
                hold_d <= din; hold_k <= kind; empty_q <= 1'b0;
            end
            if (tick) begin
                if (!busy || (cnt == TW'(OSR - 1) && left == 4'd1)) begin
                    if (!empty_q) begin
                        sh <= frm; left <= nb; busy <= 1'b1; cnt <= '0; empty_q <= 1'b1;
                    end else if (busy) begin
                        busy <= 1'b0; left <= '0; cnt <= '0;
                    end
                end else if (cnt == TW'(OSR - 1)) begin
                    cnt <= '0; sh <= {1'b1, sh[FMAX-1:1]}; left <= left - 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R10: an idle transmitter holds the line high
    p_done_line_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> txd);
    // R9: a held character moves to the shifter on the next tick when idle
    p_load_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !busy && !empty_q) |=> (empty_q && busy));
    // R8: while shifting, bits of the frame remain
    p_busy_has_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (left != 4'd0));
endmodule

// File: rtl/mv_uart.sv
// Top: tick generator, receiver and transmitter sharing one oversampling strobe.
// Assumes the host reads and writes with single-cycle strobes.
module mv_uart
    import mv_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             nine_bit,
    input  logic             tx_wr,
    input  logic [1:0]       tx_kind,
    input  logic [8:0]       tx_data,
    input  logic             rx_rd,
    input  logic             rx_sleep,
    input  logic             rxd,
    output logic             txd,
    output logic             tx_empty,
    output logic             tx_done,
    output logic [8:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_frame_err,
    output logic             rx_overrun,
    output logic             rx_asleep
);
    logic tick;

    mv_uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
    );

    mv_uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nine(nine_bit), .rxd(rxd),
        .rd(rx_rd), .sleep_req(rx_sleep), .data(rx_data), .valid(rx_valid),
        .ferr(rx_frame_err), .ovr(rx_overrun), .asleep(rx_asleep)
    );

    mv_uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .nine(nine_bit), .wr(tx_wr),
        .kind(tx_kind), .din(tx_data), .txd(txd), .empty(tx_empty), .done(tx_done)
    );
endmodule

// File: tb/sim_mv_uart.sv
`timescale 1ns/1ps
module sim_mv_uart;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd1;
    logic        nine_bit = 1'b0;
    logic        tx_wr = 1'b0;
    logic [1:0]  tx_kind = 2'b00;
    logic [8:0]  tx_data = '0;
    logic        rx_rd = 1'b0;
    logic        rx_sleep = 1'b0;
    logic        rxd_b = 1'b1;
    logic        lb = 1'b0;
    logic        rxd;
    logic        txd, tx_empty, tx_done, rx_valid, rx_frame_err, rx_overrun, rx_asleep;
    logic [8:0]  rx_data;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;
    assign rxd = lb ? txd : rxd_b;

    mv_uart u0 (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .nine_bit(nine_bit),
        .tx_wr(tx_wr), .tx_kind(tx_kind), .tx_data(tx_data), .rx_rd(rx_rd),
        .rx_sleep(rx_sleep), .rxd(rxd), .txd(txd), .tx_empty(tx_empty),
        .tx_done(tx_done), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun), .rx_asleep(rx_asleep)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_tx(input logic [1:0] k, input logic [8:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_kind = k; tx_data = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!tx_done && k < 5000) begin @(negedge clk); k++; end
    endtask

    task automatic wait_valid();
        int k = 0;
        while (!rx_valid && k < 2000) begin @(negedge clk); k++; end
    endtask

    function automatic logic [10:0] mk(input logic [8:0] d, input logic n9, input logic stopb);
        if (n9) return {stopb, d, 1'b0};
        return {1'b1, stopb, d[7:0], 1'b0};
    endfunction

    // Drive one frame on the line; gbit selects a bit that gets a 2-clock glitch at tick 8.
    task automatic drive_frame(input logic [10:0] bits, input int nb, input int bclk, input int gbit);
        for (int i = 0; i < nb; i++) begin
            rxd_b = bits[i];
            for (int c = 0; c < bclk; c++) begin
                @(negedge clk);
                if (i == gbit && c == 16) rxd_b = ~bits[i];
                if (i == gbit && c == 18) rxd_b = bits[i];
            end
        end
        rxd_b = 1'b1;
        wclk(20);
    endtask

    task automatic t_reset();
        chk("R12 txd", txd, 1);
        chk("R12 tx_empty", tx_empty, 1);
        chk("R12 tx_done", tx_done, 1);
        chk("R12 rx_valid", rx_valid, 0);
        chk("R12 rx_overrun", rx_overrun, 0);
        chk("R12 rx_asleep", rx_asleep, 0);
    endtask

    task automatic t_loop8();
        lb = 1'b1;
        send_tx(2'b00, 9'h0A5);
        wclk(3);
        chk("R10 tx_done low while sending", tx_done, 0);
        chk("R9 tx_empty after load", tx_empty, 1);
        wait_done(); wclk(40);
        chk("R1 8-bit valid", rx_valid, 1);
        chk("R1 8-bit data", rx_data, 9'h0A5);
        chk("R5 no frame error", rx_frame_err, 0);
        rd_pulse();
        chk("R6 read clears valid", rx_valid, 0);
    endtask

    task automatic t_loop9();
        nine_bit = 1'b1;
        send_tx(2'b00, 9'h1C3);
        wait_done(); wclk(40);
        chk("R1 9-bit data", rx_data, 9'h1C3);
        rd_pulse();
        nine_bit = 1'b0;
    endtask

    task automatic t_break();
        int k = 0;
        int low = 0;
        send_tx(2'b10, 9'h0FF);
        while (txd && k < 10) begin @(negedge clk); k++; end
        while (!txd && low < 1000) begin @(negedge clk); low++; end
        chk("R11 break low clocks", low, 320);
        wait_done(); wclk(40);
        chk("R8 break data", rx_data, 0);
        chk("R5 break frame error", rx_frame_err, 1);
        rd_pulse();
    endtask

    task automatic t_idle();
        int low = 0;
        send_tx(2'b01, 9'h000);
        wclk(3);
        chk("R10 tx_done low during idle frame", tx_done, 0);
        for (int i = 0; i < 400; i++) begin @(negedge clk); if (!txd) low++; end
        chk("R8 idle frame line low count", low, 0);
        chk("R10 tx_done after idle frame", tx_done, 1);
        chk("R8 idle frame not received", rx_valid, 0);
    endtask

    task automatic t_queue();
        send_tx(2'b00, 9'h011);
        wclk(3);
        send_tx(2'b00, 9'h022);
        chk("R9 tx_empty low when held", tx_empty, 0);
        send_tx(2'b00, 9'h033);
        wait_valid();
        chk("R9 first char", rx_data, 9'h011);
        rd_pulse();
        wait_valid();
        chk("R9 second char", rx_data, 9'h022);
        rd_pulse();
        wait_done(); wclk(400);
        chk("R9 ignored write produced no frame", rx_valid, 0);
        lb = 1'b0; wclk(40);
    endtask

    task automatic t_glitch();
        drive_frame(mk(9'h0FF, 1'b0, 1'b1), 10, 32, 4);
        chk("R2 data glitch ignored", rx_data, 9'h0FF);
        rd_pulse();
        drive_frame(mk(9'h00F, 1'b0, 1'b1), 10, 32, 0);
        chk("R3 start glitch ignored", rx_data, 9'h00F);
        rd_pulse();
        drive_frame(mk(9'h0F0, 1'b0, 1'b1), 10, 32, 9);
        chk("R3 stop glitch no frame error", rx_frame_err, 0);
        chk("R3 stop glitch data", rx_data, 9'h0F0);
        rd_pulse();
        @(negedge clk); rxd_b = 1'b0;
        wclk(6); rxd_b = 1'b1;
        wclk(600);
        chk("R3 false start rejected", rx_valid, 0);
    endtask

    task automatic t_resync();
        drive_frame(mk(9'h055, 1'b0, 1'b1), 10, 34, -1);
        chk("R4 slow sender valid", rx_valid, 1);
        chk("R4 slow sender data", rx_data, 9'h055);
        chk("R4 slow sender stop ok", rx_frame_err, 0);
        rd_pulse();
    endtask

    task automatic t_ferr();
        drive_frame(mk(9'h03C, 1'b0, 1'b0), 10, 32, -1);
        chk("R5 bad stop flagged", rx_frame_err, 1);
        chk("R5 bad stop data", rx_data, 9'h03C);
        rd_pulse();
        drive_frame(mk(9'h081, 1'b0, 1'b1), 10, 32, -1);
        chk("R5 good stop clears flag", rx_frame_err, 0);
        rd_pulse();
    endtask

    task automatic t_overrun();
        drive_frame(mk(9'h001, 1'b0, 1'b1), 10, 32, -1);
        drive_frame(mk(9'h002, 1'b0, 1'b1), 10, 32, -1);
        chk("R6 old char kept", rx_data, 9'h001);
        chk("R6 overrun set", rx_overrun, 1);
        rd_pulse();
        chk("R6 read clears overrun", rx_overrun, 0);
        chk("R6 read clears valid", rx_valid, 0);
    endtask

    task automatic t_standby();
        @(negedge clk); rx_sleep = 1'b1;
        @(negedge clk); rx_sleep = 1'b0;
        chk("R7 standby entered", rx_asleep, 1);
        drive_frame(mk(9'h03C, 1'b0, 1'b1), 10, 32, -1);
        chk("R7 char ignored in standby", rx_valid, 0);
        wclk(140);
        chk("R7 short idle keeps standby", rx_asleep, 1);
        wclk(224);
        chk("R7 wakes after idle frame", rx_asleep, 0);
        drive_frame(mk(9'h05A, 1'b0, 1'b1), 10, 32, -1);
        chk("R7 next message received", rx_data, 9'h05A);
        rd_pulse();
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        t_reset();
        t_loop8();
        t_loop9();
        t_break();
        t_idle();
        t_queue();
        t_glitch();
        t_resync();
        t_ferr();
        t_overrun();
        t_standby();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule